// File: doc/BRIEF.md
# Processor Clock-Control Power State Controller

This block tracks which clock-control power state a processor core is in. It also decides when the internal core clock may be gated. The bus protocol, snoop processing and the caches sit outside the block. Each of them is seen only as single-cycle handshake pulses. Five states are tracked: run, halt, stop, halt-snoop and stop-snoop. A halt bus cycle moves the core from run to halt. The active-low stop-clock input pushes the core towards the stop state. A snoop pulse moves a sleeping state into its snoop variant, which is held until the snoop-done pulse arrives.

Going from run to stop takes a handshake. The block raises an acknowledge request and waits for the response-phase pulse. It then counts a fixed number of bus clocks (20 by default) before it enters stop and closes the clock gate. The four interrupt lines (INIT, SMI, NMI, INTR) are active low and are captured on their asserting edge. While the core sleeps in stop, captured interrupts stay pending. Repeats of the same kind merge into one. Pending interrupts are handed out one per cycle, in a fixed priority, only once the state is run again. Reset reinitialises everything. The one exception is stop with stop-clock still asserted: reset clears the pending interrupts and the return path but leaves the state in stop.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While reset is low, and after it is released from any state other than stop, the state is run (code 0), the clock enable is 1, the acknowledge request is 0 and no interrupt is delivered.
- R2: In run with stop-clock deasserted, a halt-cycle pulse moves the state to halt (code 1) on the next clock.
- R3: In halt, a bus-interrupt pulse returns the state to run on the next clock. An asserting edge of any interrupt line returns it one clock after the edge is sampled, and the interrupt is then delivered.
- R4: In run, a low stop-clock raises the acknowledge request from the next clock until the response pulse. The state becomes stop (code 2) on exactly the 20th clock after the clock that samples the response pulse, and the request drops then.
- R5: In stop, deasserting stop-clock returns the state to halt if stop was entered from halt, and to run if it was entered from run.
- R6: In halt with nothing pending, a low stop-clock moves the state to stop on the next clock.
- R7: A snoop pulse moves halt to halt-snoop (code 3) and stop to stop-snoop (code 4). Each snoop state holds until a snoop-done pulse, which returns it to the state it came from.
- R8: Interrupt edges seen in stop are held pending, and nothing is delivered while the state is not run.
- R9: Several edges of one interrupt type that arrive before delivery produce a single delivery. An edge of that type sampled on the very clock its pending copy is delivered re-arms it for one more delivery.
- R10: The delivery output is one-hot or zero, with bit 0 INIT, bit 1 SMI, bit 2 NMI and bit 3 INTR. Pending interrupts are delivered one per clock in the order INIT, SMI, NMI, INTR.
- R11: Reset applied in stop while stop-clock is low keeps the state in stop. It clears the pending interrupts and makes run the return state.
- R12: Deasserting stop-clock during the acknowledge or the delay count drops the request and aborts the entry; the state stays run.
- R13: The clock enable is 0 exactly in the stop and stop-snoop states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low processor reset, synchronous |
| halt_cycle | input | 1 | Pulse: a halt bus cycle has been issued |
| stop_clk_n | input | 1 | Active-low stop-clock request |
| grant_rsp_done | input | 1 | Pulse: the acknowledge's response phase has completed |
| snp_seen | input | 1 | Pulse: a snoop was detected on the bus |
| snp_done | input | 1 | Pulse: the snoop has been serviced |
| bus_irq | input | 1 | Pulse: a bus-delivered interrupt |
| irq_init_n | input | 1 | Active-low INIT line |
| irq_smi_n | input | 1 | Active-low SMI line |
| irq_nmi_n | input | 1 | Active-low NMI line |
| irq_intr_n | input | 1 | Active-low INTR line |
| pstate | output | 3 | State code: 0 run, 1 halt, 2 stop, 3 halt-snoop, 4 stop-snoop |
| core_clk_en | output | 1 | Internal clock gate enable |
| grant_ack_req | output | 1 | Stop acknowledge request |
| irq_take | output | 4 | One-hot delivery pulse (INIT, SMI, NMI, INTR in bits 0..3) |

## Verification
Delivering a pending interrupt and capturing a new edge of the same interrupt can happen on the same clock. The bench sets this up by asserting INIT and SMI together, so that SMI waits one cycle behind INIT. A fresh SMI edge is then timed to be sampled exactly when the first SMI is handed out. The result must be two SMI deliveries, not one. A behavioural model built from integers and a bit-vector is compared with every output on each clock. It confirms that the clear and the set of the pending bit on that clock leave the bit set.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_RUN      = 3'd0,
    PS_HALT     = 3'd1,
    PS_STOP     = 3'd2,
    PS_HALT_SNP = 3'd3,
    PS_STOP_SNP = 3'd4
  } pstate_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACK  = 2'd1,
    SQ_WAIT = 2'd2
  } stopseq_e;

  localparam int IRQ_N = 4;

  // lowest set bit wins: bit 0 has the highest priority
  function automatic logic [IRQ_N-1:0] first_pending(input logic [IRQ_N-1:0] p);
    return p & (~p + 1'b1);
  endfunction

  function automatic logic gate_open(input pstate_e s);
    return !((s == PS_STOP) || (s == PS_STOP_SNP));
  endfunction

endpackage

// File: rtl/pwr_delay_cnt.sv
module pwr_delay_cnt #(
  parameter int DELAY = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LOAD));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pwr_irq_latch.sv
module pwr_irq_latch
  import pwr_state_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] irq_n,
  input  logic             deliver_en,
  output logic             pend_any,
  output logic [IRQ_N-1:0] deliver
);
  logic [IRQ_N-1:0] prev_q;
  logic [IRQ_N-1:0] pend_q;
  logic [IRQ_N-1:0] evt;

  assign evt     = prev_q & ~irq_n;
  assign deliver = deliver_en ? first_pending(pend_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= irq_n;
      pend_q <= (pend_q & ~deliver) | evt;
    end
  end

  assign pend_any = |pend_q;

  assert_one_hot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(deliver));

  assert_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver != '0 && (evt & deliver) == '0) |=> ((pend_q & $past(deliver)) == '0));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_state_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    halt_cycle,
  input  logic    stop_clk_n,
  input  logic    grant_rsp_done,
  input  logic    snp_seen,
  input  logic    snp_done,
  input  logic    bus_irq,
  input  logic    pend_any,
  input  logic    dly_done,
  output logic    dly_start,
  output logic    dly_abort,
  output pstate_e state,
  output logic    ack_req
);
  pstate_e  st_q, st_d;
  stopseq_e seq_q, seq_d;
  logic     from_halt_q, from_halt_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (st_q == PS_STOP && !stop_clk_n) st_q <= PS_STOP;
      else                                st_q <= PS_RUN;
      seq_q       <= SQ_IDLE;
      from_halt_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      seq_q       <= seq_d;
      from_halt_q <= from_halt_d;
    end
  end

  always_comb begin
    st_d        = st_q;
    seq_d       = seq_q;
    from_halt_d = from_halt_q;
    dly_start   = 1'b0;
    dly_abort   = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        if (!stop_clk_n) begin
          unique case (seq_q)
            SQ_IDLE: seq_d = SQ_ACK;
            SQ_ACK: if (grant_rsp_done) begin
              seq_d     = SQ_WAIT;
              dly_start = 1'b1;
            end
            SQ_WAIT: if (dly_done) begin
              st_d        = PS_STOP;
              seq_d       = SQ_IDLE;
              from_halt_d = 1'b0;
            end
            default: seq_d = SQ_IDLE;
          endcase
        end else begin
          seq_d     = SQ_IDLE;
          dly_abort = (seq_q == SQ_WAIT);
          if (halt_cycle) st_d = PS_HALT;
        end
      end
      PS_HALT: begin
        if (pend_any || bus_irq) begin
          st_d = PS_RUN;
        end else if (!stop_clk_n) begin
          st_d        = PS_STOP;
          from_halt_d = 1'b1;
        end else if (snp_seen) begin
          st_d = PS_HALT_SNP;
        end
      end
      PS_STOP: begin
        if (stop_clk_n) begin
          st_d        = from_halt_q ? PS_HALT : PS_RUN;
          from_halt_d = 1'b0;
        end else if (snp_seen) begin
          st_d = PS_STOP_SNP;
        end
      end
      PS_HALT_SNP: if (snp_done) st_d = PS_HALT;
      PS_STOP_SNP: if (snp_done) st_d = PS_STOP;
      default:     st_d = PS_RUN;
    endcase
  end

  assign state   = st_q;
  assign ack_req = (st_q == PS_RUN) && (seq_q == SQ_ACK);

  assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(st_q) == PS_RUN && st_q == PS_HALT) |-> $past(halt_cycle));

  assert_stop_after_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(st_q) == PS_RUN && st_q == PS_STOP) |-> $past(dly_done));

  assert_snoop_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(st_q) == PS_HALT_SNP && st_q != PS_HALT_SNP) |-> (st_q == PS_HALT));

  assert_reset_keeps_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && $past(st_q) == PS_STOP && !$past(stop_clk_n)) |-> (st_q == PS_STOP));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int GRANT_DELAY = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_cycle,
  input  logic       stop_clk_n,
  input  logic       grant_rsp_done,
  input  logic       snp_seen,
  input  logic       snp_done,
  input  logic       bus_irq,
  input  logic       irq_init_n,
  input  logic       irq_smi_n,
  input  logic       irq_nmi_n,
  input  logic       irq_intr_n,
  output logic [2:0] pstate,
  output logic       core_clk_en,
  output logic       grant_ack_req,
  output logic [3:0] irq_take
);
  pstate_e          state;
  logic             pend_any;
  logic             dly_start, dly_abort, dly_busy, dly_done;
  logic [IRQ_N-1:0] irq_lines;

  assign irq_lines = {irq_intr_n, irq_nmi_n, irq_smi_n, irq_init_n};

  pwr_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_cycle     (halt_cycle),
    .stop_clk_n     (stop_clk_n),
    .grant_rsp_done (grant_rsp_done),
    .snp_seen       (snp_seen),
    .snp_done       (snp_done),
    .bus_irq        (bus_irq),
    .pend_any       (pend_any),
    .dly_done       (dly_done),
    .dly_start      (dly_start),
    .dly_abort      (dly_abort),
    .state          (state),
    .ack_req        (grant_ack_req)
  );

  pwr_delay_cnt #(.DELAY(GRANT_DELAY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dly_start),
    .abort (dly_abort),
    .busy  (dly_busy),
    .done  (dly_done)
  );

  pwr_irq_latch u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_n      (irq_lines),
    .deliver_en (state == PS_RUN),
    .pend_any   (pend_any),
    .deliver    (irq_take)
  );

  assign pstate      = state;
  assign core_clk_en = gate_open(state);

  assert_no_take_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take != '0) |-> (state == PS_RUN));

  assert_gate_closed_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> ($past(dly_busy) || $past(state) == PS_HALT));

  assert_busy_only_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dly_busy |-> (state == PS_RUN));

endmodule

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_cycle = 1'b0, stop_clk_n = 1'b1, grant_rsp_done = 1'b0;
  logic snp_seen = 1'b0, snp_done = 1'b0, bus_irq = 1'b0;
  logic irq_init_n = 1'b1, irq_smi_n = 1'b1, irq_nmi_n = 1'b1, irq_intr_n = 1'b1;
  logic [2:0] pstate;
  logic       core_clk_en, grant_ack_req;
  logic [3:0] irq_take;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  pwr_state_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .halt_cycle(halt_cycle), .stop_clk_n(stop_clk_n),
    .grant_rsp_done(grant_rsp_done), .snp_seen(snp_seen), .snp_done(snp_done),
    .bus_irq(bus_irq), .irq_init_n(irq_init_n), .irq_smi_n(irq_smi_n),
    .irq_nmi_n(irq_nmi_n), .irq_intr_n(irq_intr_n), .pstate(pstate),
    .core_clk_en(core_clk_en), .grant_ack_req(grant_ack_req), .irq_take(irq_take)
  );

  // behavioural reference model
  int       m_st = 0, m_seq = 0, m_left = 0;
  bit       m_fh = 1'b0;
  bit [3:0] m_pend = 4'h0, m_prev = 4'hF;

  function automatic bit [3:0] m_take();
    if (m_st != 0) return 4'h0;
    for (int i = 0; i < 4; i++) if (m_pend[i]) return 4'(1 << i);
    return 4'h0;
  endfunction

  always @(posedge clk) begin
    bit [3:0] lines, evt, dl;
    bit       any_old;
    lines = {irq_intr_n, irq_nmi_n, irq_smi_n, irq_init_n};
    if (!rst_n) begin
      if (!(m_st == 2 && !stop_clk_n)) m_st = 0;
      m_seq = 0; m_fh = 0; m_pend = 0; m_prev = 4'hF;
    end else begin
      dl = m_take(); evt = m_prev & ~lines; any_old = (m_pend != 0);
      m_pend = (m_pend & ~dl) | evt;
      m_prev = lines;
      case (m_st)
        0: if (!stop_clk_n) begin
             if (m_seq == 0) m_seq = 1;
             else if (m_seq == 1) begin
               if (grant_rsp_done) begin m_seq = 2; m_left = 20; end
             end else begin
               m_left--;
               if (m_left == 0) begin m_st = 2; m_seq = 0; m_fh = 0; end
             end
           end else begin
             m_seq = 0;
             if (halt_cycle) m_st = 1;
           end
        1: if (any_old || bus_irq) m_st = 0;
           else if (!stop_clk_n) begin m_st = 2; m_fh = 1; end
           else if (snp_seen) m_st = 3;
        2: if (stop_clk_n) begin m_st = m_fh ? 1 : 0; m_fh = 0; end
           else if (snp_seen) m_st = 4;
        3: if (snp_done) m_st = 1;
        4: if (snp_done) m_st = 2;
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      total++;
      if (pstate != 3'(m_st) || core_clk_en != !(m_st == 2 || m_st == 4) ||
          grant_ack_req != (m_st == 0 && m_seq == 1) || irq_take != m_take()) begin
        bad++;
        $display("FAIL model R2/R4/R5/R6/R7/R13 cyc=%0d actual st=%0d en=%0b ack=%0b take=%h expected st=%0d take=%h",
                 cyc, pstate, core_clk_en, grant_ack_req, irq_take, m_st, m_take());
      end
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog all-R actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_st(input int exp, input string tag);
    chk(pstate == 3'(exp), tag, pstate, exp);
  endtask

  initial begin
    int n;
    bit [3:0] d0, d1, d2, d3;
    int smi_cnt;
    tick(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick(1);
    chk_st(0, "R1 reset state");
    chk(core_clk_en == 1, "R1 clk_en", core_clk_en, 1);
    chk(grant_ack_req == 0, "R1 ack", grant_ack_req, 0);
    chk(irq_take == 0, "R1 take", irq_take, 0);

    halt_cycle = 1; tick(1); halt_cycle = 0;
    chk_st(1, "R2 halt entry");
    snp_seen = 1; tick(1); snp_seen = 0;
    chk_st(3, "R7 halt snoop");
    tick(1); chk_st(3, "R7 halt snoop hold");
    snp_done = 1; tick(1); snp_done = 0;
    chk_st(1, "R7 back to halt");

    stop_clk_n = 0; tick(1);
    chk_st(2, "R6 halt to stop");
    chk(core_clk_en == 0, "R13 gate in stop", core_clk_en, 0);
    snp_seen = 1; tick(1); snp_seen = 0;
    chk_st(4, "R7 stop snoop");
    chk(core_clk_en == 0, "R13 gate in stop snoop", core_clk_en, 0);
    snp_done = 1; tick(1); snp_done = 0;
    chk_st(2, "R7 back to stop");
    stop_clk_n = 1; tick(1);
    chk_st(1, "R5 stop returns to halt");

    bus_irq = 1; tick(1); bus_irq = 0;
    chk_st(0, "R3 bus irq wake");

    halt_cycle = 1; tick(1); halt_cycle = 0;
    irq_nmi_n = 0; tick(1); irq_nmi_n = 1;
    chk_st(1, "R3 edge captured");
    tick(1);
    chk_st(0, "R3 nmi wake");
    chk(irq_take == 4'h4, "R3 nmi delivered", irq_take, 4);
    tick(1);
    chk(irq_take == 0, "R9 single delivery", irq_take, 0);

    stop_clk_n = 0; tick(1);
    chk(grant_ack_req == 1, "R4 ack raised", grant_ack_req, 1);
    tick(3);
    chk(grant_ack_req == 1, "R4 ack held", grant_ack_req, 1);
    chk_st(0, "R4 still run");
    grant_rsp_done = 1;
    n = 0;
    while (n < 40) begin
      @(posedge clk); #1;
      if (n == 0) grant_rsp_done = 0;
      n++;
      if (pstate == 3'd2) break;
    end
    chk(n - 1 == 20, "R4 delay edges", n - 1, 20);
    tick(1);
    chk(core_clk_en == 0, "R13 gate after delay", core_clk_en, 0);
    chk(grant_ack_req == 0, "R4 ack dropped", grant_ack_req, 0);

    for (int k = 0; k < 3; k++) begin
      irq_smi_n = 0; tick(1); irq_smi_n = 1; tick(1);
    end
    irq_init_n = 0; tick(1); irq_init_n = 1;
    irq_intr_n = 0; tick(1); irq_intr_n = 1; tick(1);
    chk_st(2, "R8 stay in stop");
    chk(irq_take == 0, "R8 no delivery asleep", irq_take, 0);
    stop_clk_n = 1; tick(1);
    chk_st(0, "R5 stop returns to run");
    d0 = irq_take; tick(1); d1 = irq_take; tick(1); d2 = irq_take; tick(1); d3 = irq_take;
    chk(d0 == 4'h1, "R10 first INIT", d0, 1);
    chk(d1 == 4'h2, "R10 then SMI", d1, 2);
    chk(d2 == 4'h8, "R10 then INTR", d2, 8);
    chk(d3 == 4'h0, "R10 then none", d3, 0);
    smi_cnt = int'(d0[1]) + int'(d1[1]) + int'(d2[1]) + int'(d3[1]);
    chk(smi_cnt == 1, "R9 three SMI collapse", smi_cnt, 1);

    irq_init_n = 0; irq_smi_n = 0; tick(1);
    irq_init_n = 1; irq_smi_n = 1;
    chk(irq_take == 4'h1, "R10 INIT before SMI", irq_take, 1);
    tick(1); irq_smi_n = 0;
    chk(irq_take == 4'h2, "R10 SMI next", irq_take, 2);
    tick(1); irq_smi_n = 1;
    chk(irq_take == 4'h2, "R9 rearm same cycle", irq_take, 2);
    tick(1);
    chk(irq_take == 4'h0, "R9 rearm once", irq_take, 0);

    halt_cycle = 1; tick(1); halt_cycle = 0;
    stop_clk_n = 0; tick(1);
    chk_st(2, "R6 stop from halt");
    irq_nmi_n = 0; tick(1); irq_nmi_n = 1;
    rst_n = 0; tick(2);
    chk_st(2, "R11 reset keeps stop");
    chk(core_clk_en == 0, "R11 gate stays closed", core_clk_en, 0);
    rst_n = 1; tick(1);
    chk_st(2, "R11 after release");
    stop_clk_n = 1; tick(1);
    chk_st(0, "R11 return to run");
    chk(irq_take == 0, "R11 pending cleared", irq_take, 0);
    tick(1);
    chk(irq_take == 0, "R11 pending cleared later", irq_take, 0);

    halt_cycle = 1; tick(1); halt_cycle = 0;
    rst_n = 0; tick(1);
    chk_st(0, "R1 reset from halt");
    rst_n = 1; tick(1);

    stop_clk_n = 0; tick(1);
    grant_rsp_done = 1; tick(1); grant_rsp_done = 0;
    tick(5);
    stop_clk_n = 1; tick(1);
    chk(grant_ack_req == 0, "R12 ack dropped", grant_ack_req, 0);
    chk_st(0, "R12 abort stays run");
    tick(25);
    chk_st(0, "R12 no late stop");
    chk(core_clk_en == 1, "R12 gate open", core_clk_en, 1);

    tick(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule